// File: doc/BRIEF.md
# Falling-Edge Wake-Up Interrupt Controller

This block watches two general-purpose ports of `PORT_W` pins each and raises a single shared interrupt when a falling edge occurs on a pin whose wake-up enable is set. Every pin that can wake the device has a sticky flag bit. The interrupt line is high while any flag bit and its enable bit are both set. One pin, bit 7 of port 0 by default, is reserved for another function and never takes part in wake-up.

The block only sees the level present on each pad. That level is the driven value when the pin is an output and the external value when it is an input, so edges are caught the same way in either direction. While `stop_mode` is low, a falling edge is found with a synchronizer followed by an edge detector, and no width check is applied. While `stop_mode` is high, a pin must stay low for `FILT_CYC` consecutive clock cycles before its edge counts. An accepted edge on an enabled pin in this mode also produces a one-cycle `wake` pulse, which the power controller uses to leave stop mode on the following cycle.

Software accesses four registers through a small write port and a combinational read port. Address 0 holds the port 0 flags and address 1 the port 1 flags. Address 2 holds the port 0 enables and address 3 the port 1 enables. Within each register, bit i corresponds to pin i of that port.

Top module: `keywake_ctrl`

## Requirements
- R1: After reset, all four registers read 0, `irq` is low and `wake` is low.
- R2: In run mode (`stop_mode`=0), a falling edge on an enabled pin sets that pin's flag (address 0 bit i for port 0 pin i, address 1 bit i for port 1 pin i). Enables written to addresses 2 and 3 read back unchanged, except for the reserved bit.
- R3: A rising edge never sets a flag, and a falling edge on a pin whose enable is 0 leaves its flag at 0.
- R4: `irq` is 1 exactly when some flag bit and its matching enable bit are both 1. Clearing the enable drops `irq` while the flag stays set.
- R5: Writing 1 to a flag bit clears it. Writing 0 to a flag bit leaves it unchanged.
- R6: When a new edge on a pin arrives in the same cycle as a write-1-to-clear of that pin's flag, the flag remains set.
- R7: Port 0 bit 7 is reserved. Its flag and enable bits always read 0, and an edge on that pin never sets a flag or raises `irq`.
- R8: In stop mode, a low pulse lasting fewer than `FILT_CYC` clock cycles sets no flag and produces no `wake` pulse.
- R9: In stop mode, a low level lasting `FILT_CYC` cycles or longer on an enabled pin sets its flag and produces exactly one one-cycle `wake` pulse, even if the low level is held much longer.
- R10: In run mode, a low pulse only one cycle wide still sets the flag, because no width filtering is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_mode | input | 1 | 1 selects the filtered stop-mode path |
| port0_lvl | input | PORT_W | Observed pad levels of port 0 |
| port1_lvl | input | PORT_W | Observed pad levels of port 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0/1 flags, 2/3 enables) |
| wr_data | input | PORT_W | Write data (write 1 to clear, for flag registers) |
| rd_addr | input | 2 | Read address |
| rd_data | output | PORT_W | Combinational read data |
| irq | output | 1 | Shared wake-up interrupt request |
| wake | output | 1 | One-cycle pulse on an accepted stop-mode edge |

## Verification
Several properties are checked on every cycle:
- no flag bit drops without a clear write;
- no flag bit rises unless its enable was set;
- no edge event appears while the synchronized level is high;
- a filtered stop-mode event always follows a low sample;
- `wake` only follows a cycle spent in stop mode and is backed by a flag.

The directed scenarios are needed for the rest:
- the exact filter threshold, where three low cycles are rejected and four are accepted;
- the single pulse during a long hold;
- the clear-versus-edge collision, which is timed to the exact cycle;
- the masking of the reserved pin.

// File: rtl/keywake_pkg.sv
package keywake_pkg;

   // Register map: bit 1 selects enables, bit 0 selects the port
   typedef enum logic [1:0] {
      KW_FLAG_P0 = 2'd0,
      KW_FLAG_P1 = 2'd1,
      KW_EN_P0   = 2'd2,
      KW_EN_P1   = 2'd3
   } kw_reg_e;

   localparam int unsigned KW_NUM_PORTS = 2;

endpackage

// File: rtl/keywake_pin_filter.sv
// Per-pin synchronizer, run-mode edge detector and stop-mode low-run filter
module keywake_pin_filter #(
   parameter int unsigned FILT_CYC    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_mode,
   input  logic pin_lvl,
   output logic evt
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   lvl;
   logic                   run_fall;
   logic                   stop_fall;

   assign lvl = sync_q[SYNC_STAGES-1];

   // pads idle high, so the chain resets to 1 to avoid a fake edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_lvl};
         prev_q <= lvl;
      end
   end

   assign run_fall = prev_q & ~lvl;

   generate
      if (FILT_CYC <= 1) begin : g_nofilt
         assign stop_fall = run_fall;
      end else begin : g_filt
         localparam int unsigned CW = $clog2(FILT_CYC + 1);
         logic [CW-1:0] low_cnt;

         // saturating count of consecutive low samples
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               low_cnt <= '0;
            else if (lvl)
               low_cnt <= '0;
            else if (low_cnt != CW'(FILT_CYC))
               low_cnt <= low_cnt + CW'(1);
         end

         assign stop_fall = ~lvl & (low_cnt == CW'(FILT_CYC - 1));

         assert_filter_prior_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
            stop_fall |-> $past(!lvl));
      end
   endgenerate

   assign evt = stop_mode ? stop_fall : run_fall;

   assert_no_rise_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> !lvl);

endmodule

// File: rtl/keywake_regs.sv
// Sticky flags (write 1 to clear) and enable registers with readback
module keywake_regs
   import keywake_pkg::*;
#(
   parameter int unsigned    PORT_W     = 8,
   parameter int unsigned    NPIN       = 2 * PORT_W,
   parameter logic [NPIN-1:0] VALID_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPIN-1:0]   evt,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [PORT_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [PORT_W-1:0] rd_data,
   output logic [NPIN-1:0]   flags,
   output logic [NPIN-1:0]   enables
);

   logic [NPIN-1:0] flags_q;
   logic [NPIN-1:0] en_q;
   logic [NPIN-1:0] clr_mask;
   logic [NPIN-1:0] en_next;

   always_comb begin
      clr_mask = '0;
      en_next  = en_q;
      for (int p = 0; p < KW_NUM_PORTS; p++) begin
         if (wr_en && (wr_addr[0] == p[0])) begin
            if (wr_addr[1])
               en_next[p*PORT_W +: PORT_W] = wr_data;
            else
               clr_mask[p*PORT_W +: PORT_W] = wr_data;
         end
      end
   end

   // set beats clear so a colliding edge is never lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         en_q    <= '0;
      end else begin
         flags_q <= ((flags_q & ~clr_mask) | (evt & en_q)) & VALID_MASK;
         en_q    <= en_next & VALID_MASK;
      end
   end

   always_comb begin
      case (kw_reg_e'(rd_addr))
         KW_FLAG_P0: rd_data = flags_q[0      +: PORT_W];
         KW_FLAG_P1: rd_data = flags_q[PORT_W +: PORT_W];
         KW_EN_P0:   rd_data = en_q[0         +: PORT_W];
         default:    rd_data = en_q[PORT_W    +: PORT_W];
      endcase
   end

   assign flags   = flags_q;
   assign enables = en_q;

   assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(flags_q) & ~$past(clr_mask)) & ~flags_q) == '0);

   assert_set_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags_q & ~$past(flags_q)) & ~$past(en_q)) == '0);

endmodule

// File: rtl/keywake_ctrl.sv
// Falling-edge wake-up interrupt controller, two ports
module keywake_ctrl
   import keywake_pkg::*;
#(
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned FILT_CYC    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned EXCL_PORT   = 0,
   parameter int unsigned EXCL_BIT    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_mode,
   input  logic [PORT_W-1:0] port0_lvl,
   input  logic [PORT_W-1:0] port1_lvl,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [PORT_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [PORT_W-1:0] rd_data,
   output logic              irq,
   output logic              wake
);

   localparam int unsigned     NPIN       = KW_NUM_PORTS * PORT_W;
   localparam int unsigned     EXCL_IDX   = EXCL_PORT * PORT_W + EXCL_BIT;
   localparam logic [NPIN-1:0] VALID_MASK = ~(NPIN'(1) << EXCL_IDX);

   generate
      if (PORT_W < 2 || PORT_W > 16) begin : g_bad_width
         $error("keywake_ctrl: PORT_W out of range");
      end
      if (EXCL_PORT >= KW_NUM_PORTS || EXCL_BIT >= PORT_W) begin : g_bad_excl
         $error("keywake_ctrl: reserved pin outside the ports");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("keywake_ctrl: SYNC_STAGES must be at least 2");
      end
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("keywake_ctrl: FILT_CYC must be at least 1");
      end
   endgenerate

   logic [NPIN-1:0] pins;
   logic [NPIN-1:0] evt;
   logic [NPIN-1:0] flags;
   logic [NPIN-1:0] enables;
   logic            wake_q;

   assign pins = {port1_lvl, port0_lvl};

   generate
      for (genvar i = 0; i < NPIN; i++) begin : g_pin
         keywake_pin_filter #(
            .FILT_CYC   (FILT_CYC),
            .SYNC_STAGES(SYNC_STAGES)
         ) u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .stop_mode(stop_mode),
            .pin_lvl  (pins[i]),
            .evt      (evt[i])
         );
      end
   endgenerate

   keywake_regs #(
      .PORT_W    (PORT_W),
      .NPIN      (NPIN),
      .VALID_MASK(VALID_MASK)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(rd_addr),
      .rd_data(rd_data),
      .flags  (flags),
      .enables(enables)
   );

   assign irq = |(flags & enables);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wake_q <= 1'b0;
      else
         wake_q <= stop_mode & |(evt & enables);
   end

   assign wake = wake_q;

   assert_wake_from_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> $past(stop_mode));

   assert_wake_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (flags != '0));

   assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!enables[EXCL_IDX]) |-> !flags[EXCL_IDX]);

endmodule

// File: tb/keywake_ctrl_bench.sv
module keywake_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int FILT       = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stop_mode = 1'b0;
   logic [7:0] p0 = 8'hFF;
   logic [7:0] p1 = 8'hFF;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       irq;
   logic       wake;

   int n_chk  = 0;
   int n_fail = 0;
   int wake_cnt = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   keywake_ctrl u_keywake_ctrl (
      .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode),
      .port0_lvl(p0), .port1_lvl(p1),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .wake(wake)
   );

   always @(negedge clk) if (wake) wake_cnt++;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   // hold one pin low for n sampling edges, then release
   task automatic pulse(input bit port, input int bitn, input int n);
      if (port) p1[bitn] = 1'b0; else p0[bitn] = 1'b0;
      repeat (n) @(posedge clk);
      @(negedge clk);
      if (port) p1[bitn] = 1'b1; else p0[bitn] = 1'b1;
      cyc(5);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], d);
         chk("R1 reg after reset", d, 0);
      end
      chk("R1 irq after reset", irq, 0);
      chk("R1 wake after reset", wake, 0);
   endtask

   task automatic t_run_edge;
      logic [7:0] d;
      wr(2'd2, 8'h0F);
      wr(2'd3, 8'hFF);
      rd(2'd2, d); chk("R2 enable p0 readback", d, 8'h0F);
      rd(2'd3, d); chk("R2 enable p1 readback", d, 8'hFF);
      pulse(0, 2, 1);
      rd(2'd0, d); chk("R10 one-cycle pulse sets flag p0 bit2", d, 8'h04);
      chk("R4 irq with flag and enable", irq, 1);
      pulse(1, 7, 2);
      rd(2'd1, d); chk("R2 flag p1 bit7", d, 8'h80);
   endtask

   task automatic t_w1c;
      logic [7:0] d;
      wr(2'd0, 8'h00);
      rd(2'd0, d); chk("R5 write 0 keeps flag", d, 8'h04);
      wr(2'd0, 8'h04);
      rd(2'd0, d); chk("R5 write 1 clears p0", d, 8'h00);
      wr(2'd1, 8'h80);
      rd(2'd1, d); chk("R5 write 1 clears p1", d, 8'h00);
      chk("R4 irq low with no flags", irq, 0);
   endtask

   task automatic t_rise_disabled;
      logic [7:0] d;
      p0[5] = 1'b0;
      cyc(6);
      rd(2'd0, d); chk("R3 disabled pin falling edge", d, 8'h00);
      wr(2'd2, 8'h2F);
      p0[5] = 1'b1;
      cyc(6);
      rd(2'd0, d); chk("R3 rising edge sets nothing", d, 8'h00);
      wr(2'd2, 8'h0F);
   endtask

   task automatic t_irq_mask;
      logic [7:0] d;
      pulse(0, 0, 2);
      chk("R4 irq raised", irq, 1);
      wr(2'd2, 8'h00);
      chk("R4 irq drops with enable cleared", irq, 0);
      rd(2'd0, d); chk("R4 flag kept while disabled", d, 8'h01);
      wr(2'd2, 8'h0F);
      chk("R4 irq returns on re-enable", irq, 1);
      wr(2'd0, 8'h01);
   endtask

   task automatic t_reserved;
      logic [7:0] d;
      wr(2'd2, 8'hFF);
      rd(2'd2, d); chk("R7 reserved enable reads 0", d, 8'h7F);
      pulse(0, 7, 3);
      rd(2'd0, d); chk("R7 reserved flag stays 0", d, 8'h00);
      chk("R7 no irq from reserved pin", irq, 0);
      wr(2'd2, 8'h0F);
   endtask

   task automatic t_clear_race;
      logic [7:0] d;
      pulse(0, 1, 1);
      p0[1] = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      wr(2'd0, 8'h02);
      rd(2'd0, d); chk("R6 edge wins over clear", d, 8'h02);
      p0[1] = 1'b1;
      cyc(3);
      wr(2'd0, 8'h02);
      rd(2'd0, d); chk("R6 later clear works", d, 8'h00);
   endtask

   task automatic t_stop_filter;
      logic [7:0] d;
      stop_mode = 1'b1;
      cyc(2);
      wake_cnt = 0;
      pulse(0, 3, FILT - 1);
      cyc(4);
      rd(2'd0, d); chk("R8 short stop pulse sets no flag", d, 8'h00);
      chk("R8 short stop pulse no wake", wake_cnt, 0);
      pulse(0, 3, FILT);
      rd(2'd0, d); chk("R9 threshold pulse sets flag", d, 8'h08);
      chk("R9 one wake pulse", wake_cnt, 1);
      pulse(1, 0, 12);
      rd(2'd1, d); chk("R9 long hold sets p1 flag", d, 8'h01);
      chk("R9 long hold single wake", wake_cnt, 2);
      stop_mode = 1'b0;
      wr(2'd0, 8'hFF);
      wr(2'd1, 8'hFF);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      cyc(3);
      t_reset();
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_run_edge();
      t_w1c();
      t_rise_disabled();
      t_irq_mask();
      t_reserved();
      t_clear_race();
      t_stop_filter();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule